// File: doc/BRIEF.md
# Encoder Position Status Comparator

This block turns each new absolute position sample from an encoder front end into a word of status bits. It places the sample inside or outside a window set by a lower and an upper bound. It works out whether the position rose or fell since the previous good sample. It also compares the sample against a programmable reference value and keeps a sticky match flag, which a command clears. An enable mask selects which status bits feed a single diagnostic summary output.

All status bits except the summary are registered. They change only on the clock edge that accepts a sample, and they hold between samples. The sticky flag is the exception, because a clear command can reset it on any cycle. The position and all reference values are unsigned and share one parameterised width.

Top module: `pos_status_cmp`

## Requirements
- R1: `stat_under` is 1 when the accepted sample is strictly below `lo_limit`. It is 0 when the sample is equal to or above `lo_limit`.
- R2: `stat_over` is 1 when the accepted sample is strictly above `hi_limit`. It is 0 when the sample is equal to or below `hi_limit`.
- R3: `stat_up` is 1 only when the sample is larger than the stored previous position. `stat_down` is 1 only when the sample is smaller. Both are 0 when the sample equals the stored position.
- R4: After reset, both direction bits stay 0 until a previous position has been stored. A previous position is stored only by an accepted sample taken while `enc_fault` is 0.
- R5: A sample accepted while `enc_fault` is 1 does not replace the stored previous position. The next sample is compared against the last position stored while the fault was 0.
- R6: `cmp_ge` is 1 when the sample is greater than or equal to `cmp_value`, and 0 otherwise.
- R7: `cmp_eq` is 1 when the most recent sample equals `cmp_value`, and 0 otherwise.
- R8: `cmp_flag` is 0 after reset. It becomes 1 on the edge that accepts a sample equal to `cmp_value`. It stays 1 until an edge where `clr_match` is 1, and `clr_match` acts with or without a sample.
- R9: If `clr_match` is 1 on the same edge as an accepted equal sample, `cmp_flag` ends up 1.
- R10: `diag` is 1 when any bit of the status vector ANDed with `stat_en` is 1. The status vector is, from bit 0 to bit 7: under, over, enc_err, up, down, cmp_ge, cmp_flag, cmp_eq.
- R11: All status outputs except `cmp_flag` change only on the edge where `pos_valid` is 1. The new values appear one cycle after the strobe, and the outputs hold their values otherwise.
- R12: All comparisons are unsigned. A sample with the top bit set counts as larger than any smaller value.
- R13: After reset, every status output and `diag` are 0.
- R14: `enc_err` takes the value of `enc_fault` present on the edge that accepts a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_valid | input | 1 | Strobe that marks `pos_in` as a new sample |
| pos_in | input | W | Position sample |
| lo_limit | input | W | Lower window bound |
| hi_limit | input | W | Upper window bound |
| cmp_value | input | W | Compare reference |
| stat_en | input | 8 | Enable mask for the diagnostic summary |
| clr_match | input | 1 | Clears the sticky match flag |
| enc_fault | input | 1 | Encoder signal fault indication |
| stat_under | output | 1 | Sample below the lower bound |
| stat_over | output | 1 | Sample above the upper bound |
| enc_err | output | 1 | Fault captured with the sample |
| stat_up | output | 1 | Position increased |
| stat_down | output | 1 | Position decreased |
| cmp_ge | output | 1 | Sample at or above the reference |
| cmp_flag | output | 1 | Sticky equality flag |
| cmp_eq | output | 1 | Sample equals the reference |
| diag | output | 1 | Masked OR of the status vector |

## Verification
The bench places samples exactly on each bound. A design that used the wrong relational operator would set the underflow or overflow bit at the boundary value. A sample taken under a fault is followed by a good sample that lies between the faulty value and the last good one. A design that stored the faulty value would report the wrong direction on that good sample. The bench also drives a clear on the same edge as a new match, and a flag that lost that match would read 0. A sample of all ones catches any signed comparison, which would report it as below the lower bound. Direction gating is checked after a mid-run reset, including a first sample taken under a fault, where a design that counted that sample would assert a direction too early.

// File: rtl/pos_status_pkg.sv
package pos_status_pkg;

    localparam int NSTAT = 8;

    // Status word, bit 0 = under ... bit 7 = eq
    typedef struct packed {
        logic eq;
        logic flag;
        logic ge;
        logic down;
        logic up;
        logic err;
        logic over;
        logic under;
    } status_t;

    // Window and reference relations of one sample
    typedef struct packed {
        logic under;
        logic over;
        logic ge;
        logic eq;
    } rel_t;

    // Registered per-sample measurement (everything but the sticky flag)
    typedef struct packed {
        rel_t rel;
        logic up;
        logic down;
        logic err;
    } meas_t;

    function automatic logic [NSTAT-1:0] status_vec(input meas_t m, input logic flag);
        status_t s;
        s.under = m.rel.under;
        s.over  = m.rel.over;
        s.err   = m.err;
        s.up    = m.up;
        s.down  = m.down;
        s.ge    = m.rel.ge;
        s.flag  = flag;
        s.eq    = m.rel.eq;
        return s;
    endfunction

endpackage

// File: rtl/pos_window_cmp.sv
module pos_window_cmp
    import pos_status_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] ref_val,
    output rel_t         rel
);

    always_comb begin
        rel.under = (pos < lo);
        rel.over  = (pos > hi);
        rel.ge    = (pos >= ref_val);
        rel.eq    = (pos == ref_val);
    end

endmodule

// File: rtl/pos_dir_track.sv
module pos_dir_track #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample,
    input  logic         fault,
    input  logic [W-1:0] pos,
    output logic         up_nxt,
    output logic         down_nxt
);

    logic [W-1:0] prev_q;
    logic         have_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (sample && !fault) begin
            prev_q      <= pos;
            have_prev_q <= 1'b1;
        end
    end

    always_comb begin
        up_nxt   = have_prev_q && (pos > prev_q);
        down_nxt = have_prev_q && (pos < prev_q);
    end

endmodule

// File: rtl/pos_match_flag.sv
module pos_match_flag (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic eq_now,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)                  flag <= 1'b0;
        else if (sample && eq_now) flag <= 1'b1;
        else if (clr)             flag <= 1'b0;
    end

endmodule

// File: rtl/pos_status_cmp.sv
module pos_status_cmp
    import pos_status_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pos_valid,
    input  logic [W-1:0]     pos_in,
    input  logic [W-1:0]     lo_limit,
    input  logic [W-1:0]     hi_limit,
    input  logic [W-1:0]     cmp_value,
    input  logic [NSTAT-1:0] stat_en,
    input  logic             clr_match,
    input  logic             enc_fault,
    output logic             stat_under,
    output logic             stat_over,
    output logic             enc_err,
    output logic             stat_up,
    output logic             stat_down,
    output logic             cmp_ge,
    output logic             cmp_flag,
    output logic             cmp_eq,
    output logic             diag
);

    rel_t             rel_now;
    logic             up_nxt, down_nxt;
    meas_t            meas_q;
    logic             flag_q;
    logic [NSTAT-1:0] vec;

    pos_window_cmp #(.W(W)) u_win (
        .pos     (pos_in),
        .lo      (lo_limit),
        .hi      (hi_limit),
        .ref_val (cmp_value),
        .rel     (rel_now)
    );

    pos_dir_track #(.W(W)) u_dir (
        .clk      (clk),
        .rst      (rst),
        .sample   (pos_valid),
        .fault    (enc_fault),
        .pos      (pos_in),
        .up_nxt   (up_nxt),
        .down_nxt (down_nxt)
    );

    pos_match_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .sample (pos_valid),
        .eq_now (rel_now.eq),
        .clr    (clr_match),
        .flag   (flag_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            meas_q <= '0;
        end else if (pos_valid) begin
            meas_q.rel  <= rel_now;
            meas_q.up   <= up_nxt;
            meas_q.down <= down_nxt;
            meas_q.err  <= enc_fault;
        end
    end

    assign vec        = status_vec(meas_q, flag_q);
    assign diag       = |(vec & stat_en);

    assign stat_under = meas_q.rel.under;
    assign stat_over  = meas_q.rel.over;
    assign enc_err    = meas_q.err;
    assign stat_up    = meas_q.up;
    assign stat_down  = meas_q.down;
    assign cmp_ge     = meas_q.rel.ge;
    assign cmp_flag   = flag_q;
    assign cmp_eq     = meas_q.rel.eq;

endmodule

// File: rtl/pos_status_cmp_chk.sv
module pos_status_cmp_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         pos_valid,
    input logic [W-1:0] pos_in,
    input logic [W-1:0] lo_limit,
    input logic [W-1:0] hi_limit,
    input logic [W-1:0] cmp_value,
    input logic         enc_fault,
    input logic         stat_under,
    input logic         stat_over,
    input logic         enc_err,
    input logic         stat_up,
    input logic         stat_down,
    input logic         cmp_ge,
    input logic         cmp_flag,
    input logic         cmp_eq
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1
    under_lo_chk: assert property (@(posedge clk) disable iff (rst)
        armed && $past(pos_valid) |-> stat_under == ($past(pos_in) < $past(lo_limit)));

    // R2
    over_hi_chk: assert property (@(posedge clk) disable iff (rst)
        armed && $past(pos_valid) |-> stat_over == ($past(pos_in) > $past(hi_limit)));

    // R3
    dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stat_up && stat_down));

    // R7
    eq_ge_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_eq |-> cmp_ge);

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        armed && $past(pos_valid && (pos_in == cmp_value)) |-> cmp_flag);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        armed && !$past(pos_valid) |-> $stable(stat_under) && $stable(stat_over) &&
            $stable(stat_up) && $stable(stat_down) && $stable(cmp_ge) && $stable(cmp_eq) &&
            $stable(enc_err));

    // R14
    err_cap_chk: assert property (@(posedge clk) disable iff (rst)
        armed && $past(pos_valid) |-> enc_err == $past(enc_fault));

endmodule

bind pos_status_cmp pos_status_cmp_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pos_valid  (pos_valid),
    .pos_in     (pos_in),
    .lo_limit   (lo_limit),
    .hi_limit   (hi_limit),
    .cmp_value  (cmp_value),
    .enc_fault  (enc_fault),
    .stat_under (stat_under),
    .stat_over  (stat_over),
    .enc_err    (enc_err),
    .stat_up    (stat_up),
    .stat_down  (stat_down),
    .cmp_ge     (cmp_ge),
    .cmp_flag   (cmp_flag),
    .cmp_eq     (cmp_eq)
);

// File: tb/pos_status_cmp_tb.sv
module pos_status_cmp_tb;

    localparam int W  = 32;
    localparam int NV = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pos_valid = 1'b0;
    logic [W-1:0] pos_in = '0;
    logic [W-1:0] lo_limit = 32'd100;
    logic [W-1:0] hi_limit = 32'd200;
    logic [W-1:0] cmp_value = 32'd150;
    logic [7:0]   stat_en = 8'h00;
    logic         clr_match = 1'b0;
    logic         enc_fault = 1'b0;
    logic stat_under, stat_over, enc_err, stat_up, stat_down, cmp_ge, cmp_flag, cmp_eq, diag;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pos_status_cmp #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .pos_valid(pos_valid), .pos_in(pos_in),
        .lo_limit(lo_limit), .hi_limit(hi_limit), .cmp_value(cmp_value),
        .stat_en(stat_en), .clr_match(clr_match), .enc_fault(enc_fault),
        .stat_under(stat_under), .stat_over(stat_over), .enc_err(enc_err),
        .stat_up(stat_up), .stat_down(stat_down), .cmp_ge(cmp_ge),
        .cmp_flag(cmp_flag), .cmp_eq(cmp_eq), .diag(diag)
    );

    // Vector table, window fixed at [100,200]; expected bit order
    // 0 under,1 over,2 err,3 up,4 down,5 ge,6 flag,7 eq
    localparam logic [W-1:0] V_POS [NV] = '{32'd50, 32'd100, 32'd150, 32'd150, 32'd200,
                                            32'd201, 32'd120, 32'd130, 32'd130, 32'hFFFF_FFFF};
    localparam logic [W-1:0] V_CMP [NV] = '{32'd150, 32'd150, 32'd150, 32'd150, 32'd150,
                                            32'd150, 32'd150, 32'd150, 32'd130, 32'd5};
    localparam logic [NV-1:0] V_CLR = 10'b01_0010_0000; // rows 5 and 8 (0-based)
    localparam logic [NV-1:0] V_FLT = 10'b00_0100_0000; // row 6
    localparam logic [7:0] V_EXP [NV] = '{8'b0000_0001, 8'b0000_1000, 8'b1110_1000,
                                          8'b1110_0000, 8'b0110_1000, 8'b0010_1010,
                                          8'b0001_0100, 8'b0001_0000, 8'b1110_0000,
                                          8'b0110_1010};
    localparam string V_REQ [NV] = '{"R1", "R1 R3", "R3 R6 R7 R8", "R3", "R2 R7",
                                     "R2 R8", "R3 R14", "R5", "R9", "R12"};

    function automatic logic [7:0] stat_now();
        return {cmp_eq, cmp_flag, cmp_ge, stat_down, stat_up, enc_err, stat_over, stat_under};
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic sample(input logic [W-1:0] p, input logic [W-1:0] c,
                          input logic clr, input logic flt);
        @(negedge clk);
        pos_in = p; cmp_value = c; clr_match = clr; enc_fault = flt; pos_valid = 1'b1;
        @(negedge clk);
        pos_valid = 1'b0; clr_match = 1'b0; enc_fault = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        stat_en = 8'hFF;
        #1;
        // R13: reset state
        check8("R13", stat_now(), 8'h00);
        check1("R13 diag", diag, 1'b0);

        for (int i = 0; i < NV; i++) begin
            sample(V_POS[i], V_CMP[i], V_CLR[i], V_FLT[i]);
            check8(V_REQ[i], stat_now(), V_EXP[i]);
        end

        // R11: changing inputs without a strobe leaves status unchanged
        @(negedge clk);
        pos_in = 32'd0; cmp_value = 32'd0; enc_fault = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check8("R11 hold", stat_now(), 8'b0110_1010);
        enc_fault = 1'b0;

        // R8: clear without a sample
        @(negedge clk);
        clr_match = 1'b1;
        @(negedge clk);
        clr_match = 1'b0;
        check8("R8 clear", stat_now(), 8'b0010_1010);

        // R10: mask selection on status 0010_1010
        stat_en = 8'h01; #1; check1("R10 under masked", diag, 1'b0);
        stat_en = 8'h02; #1; check1("R10 over enabled", diag, 1'b1);
        stat_en = 8'h40; #1; check1("R10 flag cleared", diag, 1'b0);
        stat_en = 8'h00; #1; check1("R10 none", diag, 1'b0);
        stat_en = 8'hD5; #1; check1("R10 disjoint", diag, 1'b0);
        stat_en = 8'h20; #1; check1("R10 ge", diag, 1'b1);

        // R4: two good samples needed for direction
        do_reset();
        sample(32'd500, 32'd1, 1'b0, 1'b0);
        check1("R4 first sample", stat_up, 1'b0);
        sample(32'd600, 32'd1, 1'b0, 1'b0);
        check1("R4 second sample", stat_up, 1'b1);

        // R4: a first sample under fault does not count
        do_reset();
        sample(32'd10, 32'd1, 1'b0, 1'b1);
        check1("R4 faulty first", stat_down, 1'b0);
        sample(32'd5, 32'd1, 1'b0, 1'b0);
        check1("R4 first good", stat_down, 1'b0);
        sample(32'd7, 32'd1, 1'b0, 1'b0);
        check1("R4 second good", stat_up, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule